// File: doc/BRIEF.md
# Multi-mode Interval Timer with Input Gating

This block is a down-counting interval timer. Its time base is a fixed divide-by-4 step of the system clock, which a programmable prescaler stretches further. Each time the counter passes zero it reloads a programmed initial value and raises a one-cycle end-of-count interrupt. A run bit starts and stops the timer. An external input pin can take part in counting in one of four ways, chosen by an input-mode field:

- free-running;
- gated by the pin level;
- started by a falling edge of the pin;
- restarted by every falling edge of the pin.

The pin passes through a two-flop synchronizer inside the block before it is used.

An output stage drives a single output pin. It holds the pin high when the output is disabled. Otherwise it produces a square wave that toggles at every end of count, or a PWM level copied from a software bit at every end of count. Software writes three registers through a simple single-cycle write port.

Top module: `mode_timer`

## Requirements
- R1: After reset the output pin is high and the interrupt is low.
- R2: In free-running mode with run set, the interrupt fires every (initial+1)*(prescaler+1)*4 clock cycles.
- R3: The interrupt is a single-cycle pulse.
- R4: In gated mode the timer does not advance while the synchronized pin is low, and it advances while the pin is high.
- R5: In triggerable mode, setting run only arms the timer. Counting begins after the next high-to-low pin edge.
- R6: In retriggerable mode, each high-to-low edge reloads the initial value while running. Edges have no effect while stopped.
- R7: Clearing the run bit stops the timer in every mode, and no interrupt follows.
- R8: With the output enable bit clear, the output pin is driven high.
- R9: In square-wave mode the output pin changes level exactly at each end of count.
- R10: In PWM mode the software output bit is copied to the pin at each end of count and held until the next one.
- R11: Register map by write address:
  - address 0 holds the initial value;
  - address 1 holds the prescaler;
  - address 2 holds control, with bit0 run, bits[2:1] input mode (0 free, 1 gated, 2 triggerable, 3 retriggerable), bit3 output enable, bit4 PWM select (0 square), and bit5 PWM output bit;
  - address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| tin | input | 1 | External timer input pin (asynchronous) |
| tout | output | 1 | Timer output pin |
| eoc_irq | output | 1 | End-of-count interrupt pulse |

## Verification
The checker verifies several properties on every cycle:
- the interrupt is one cycle wide;
- the output stays high while disabled;
- the square-wave output changes exactly with the interrupt;
- no step occurs while gated low, while armed and waiting for an edge, or after run is cleared.

Only the bench scenarios can show the following:
- the exact interrupt period set by the initial and prescaler values;
- that a falling edge starts a triggerable run;
- that repeated edges hold off the retriggerable interrupt indefinitely;
- that a PWM bit change waits for the next end of count.

// File: rtl/mtmr_pkg.sv
// Shared types and register addresses for the multi-mode timer.
package mtmr_pkg;
    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_GATE   = 2'd1,
        MODE_TRIG   = 2'd2,
        MODE_RETRIG = 2'd3
    } in_mode_e;

    typedef struct packed {
        logic     pwm_bit;
        logic     pwm_mode;
        logic     out_en;
        in_mode_e mode;
        logic     run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_INIT = 2'd0;
    localparam logic [1:0] ADDR_PSC  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/mtmr_insync.sv
// Input synchronizer and falling-edge detector.
// Assumes pin is asynchronous; STAGES >= 2 flops before use.
module mtmr_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the pin through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign fall  = last_q & ~level;
endmodule

// File: rtl/mtmr_tick.sv
// Time base: fixed divide-by-DIV phase followed by a programmable prescaler.
// Issues one step per DIV*(psc_val+1) enabled cycles; restart clears both stages.
module mtmr_tick #(
    parameter int DIV   = 4,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc_val,
    output logic             step
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [PSC_W-1:0] psc_q;
    logic             phase_end;
    logic             psc_end;

    assign phase_end = (div_q == DIV_LAST);
    assign psc_end   = (psc_q == psc_val);
    assign step      = ~restart & en & phase_end & psc_end;

    // Advance the divider and prescaler while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            psc_q <= '0;
        end else if (restart) begin
            div_q <= '0;
            psc_q <= '0;
        end else if (en) begin
            if (phase_end) begin
                div_q <= '0;
                psc_q <= psc_end ? '0 : psc_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mtmr_count.sv
// Down counter with reload. End of count is a step taken while at zero.
module mtmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] init_val,
    output logic             eoc_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign eoc_evt = step & at_zero;

    // Load, decrement, or reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= init_val;
        end else if (step) begin
            cnt_q <= at_zero ? init_val : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mtmr_outstage.sv
// Output stage: registered interrupt, square-wave toggle, PWM latch.
// The pin is high when disabled.
module mtmr_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_evt,
    input  logic out_en,
    input  logic pwm_mode,
    input  logic pwm_bit,
    output logic tout,
    output logic eoc_irq
);
    logic sq_q;
    logic pwm_q;
    logic irq_q;

    // Update the wave sources and the interrupt at each end of count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q  <= 1'b0;
            pwm_q <= 1'b1;
            irq_q <= 1'b0;
        end else begin
            irq_q <= eoc_evt;
            if (eoc_evt) begin
                sq_q  <= ~sq_q;
                pwm_q <= pwm_bit;
            end
        end
    end

    assign tout    = !out_en ? 1'b1 : (pwm_mode ? pwm_q : sq_q);
    assign eoc_irq = irq_q;
endmodule

// File: rtl/mode_timer.sv
// Multi-mode timer top: register file, input-mode control, and the submodules.
// Assumes single-cycle writes. A 0->1 run write loads the counter and clears the time base.
module mode_timer
    import mtmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 8,
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tin,
    output logic             tout,
    output logic             eoc_irq
);
    logic [CNT_W-1:0] init_q;
    logic [PSC_W-1:0] psc_q;
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic             ctrl_wr;
    logic             start_pulse;
    logic             waiting_q;
    logic             pin_lvl;
    logic             pin_fall;
    logic             count_en;
    logic             restart;
    logic             step;
    logic             eoc_evt;

    assign ctrl_new    = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign ctrl_wr     = wr_en && (wr_addr == ADDR_CTRL);
    assign start_pulse = ctrl_wr && ctrl_new.run && !ctrl_q.run;

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            psc_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_INIT: init_q <= wr_data;
                ADDR_PSC:  psc_q  <= wr_data[PSC_W-1:0];
                ADDR_CTRL: ctrl_q <= ctrl_new;
                default:   ;
            endcase
        end
    end

    // Triggerable arming: wait for a falling edge after start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
        end else if (start_pulse) begin
            waiting_q <= (ctrl_new.mode == MODE_TRIG);
        end else if (!ctrl_q.run) begin
            waiting_q <= 1'b0;
        end else if (pin_fall) begin
            waiting_q <= 1'b0;
        end
    end

    // Select the count enable from the input mode.
    always_comb begin
        case (ctrl_q.mode)
            MODE_GATE: count_en = ctrl_q.run & pin_lvl;
            MODE_TRIG: count_en = ctrl_q.run & ~waiting_q;
            default:   count_en = ctrl_q.run;
        endcase
    end

    assign restart = start_pulse |
                     (ctrl_q.run & (ctrl_q.mode == MODE_RETRIG) & pin_fall);

    mtmr_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (tin),
        .level (pin_lvl),
        .fall  (pin_fall)
    );

    mtmr_tick #(.DIV(TICK_DIV), .PSC_W(PSC_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (count_en),
        .restart (restart),
        .psc_val (psc_q),
        .step    (step)
    );

    mtmr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .step     (step),
        .init_val (init_q),
        .eoc_evt  (eoc_evt)
    );

    mtmr_outstage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoc_evt  (eoc_evt),
        .out_en   (ctrl_q.out_en),
        .pwm_mode (ctrl_q.pwm_mode),
        .pwm_bit  (ctrl_q.pwm_bit),
        .tout     (tout),
        .eoc_irq  (eoc_irq)
    );
endmodule

// File: rtl/mtmr_check.sv
// Checker for the multi-mode timer, bound to the top module.
module mtmr_check (
    input logic       clk,
    input logic       rst_n,
    input logic       tout,
    input logic       eoc_irq,
    input logic       out_en,
    input logic       pwm_mode,
    input logic       run,
    input logic [1:0] mode,
    input logic       waiting,
    input logic       pin_lvl,
    input logic       step
);
    logic sq_on;
    assign sq_on = out_en & ~pwm_mode;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq); // R3
    AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> tout); // R8
    AST_SQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_on && $past(sq_on)) |-> ((!$stable(tout)) == eoc_irq)); // R9
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> !eoc_irq); // R7
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == 2'd1 && !pin_lvl) |-> !step); // R4
    AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !step); // R5
endmodule

bind mode_timer mtmr_check u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tout     (tout),
    .eoc_irq  (eoc_irq),
    .out_en   (ctrl_q.out_en),
    .pwm_mode (ctrl_q.pwm_mode),
    .run      (ctrl_q.run),
    .mode     (ctrl_q.mode),
    .waiting  (waiting_q),
    .pin_lvl  (pin_lvl),
    .step     (step)
);

// File: tb/test_mode_timer.sv
module test_mode_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        tin = 1'b0;
    logic        tout;
    logic        eoc_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    string tag  = "R1";

    mode_timer i_mode_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tin(tin), .tout(tout), .eoc_irq(eoc_irq)
    );

    always #10 clk = ~clk;

    // Behavioural reference model, stepped at each rising edge.
    int m_init, m_psc, m_run, m_mode, m_oe, m_pm, m_pb;
    int m_q1, m_q2, m_q3, m_div, m_pc, m_cnt, m_wait, m_sq, m_pwq, m_irq;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_init = 0; m_psc = 0; m_run = 0; m_mode = 0; m_oe = 0; m_pm = 0; m_pb = 0;
            m_q1 = 0; m_q2 = 0; m_q3 = 0; m_div = 0; m_pc = 0; m_cnt = 0;
            m_wait = 0; m_sq = 0; m_pwq = 1; m_irq = 0;
        end else begin
            int fall, en, start, rst_t, dec, eoc;
            fall  = (m_q3 == 1 && m_q2 == 0);
            start = (wr_en && wr_addr == 2 && wr_data[0] && m_run == 0);
            case (m_mode)
                1: en = m_run && m_q2;
                2: en = m_run && !m_wait;
                default: en = m_run;
            endcase
            rst_t = start || (m_run && m_mode == 3 && fall);
            dec   = !rst_t && en && m_div == 3 && m_pc == m_psc;
            eoc   = dec && m_cnt == 0;
            if (rst_t) begin m_div = 0; m_pc = 0; end
            else if (en) begin
                if (m_div == 3) begin m_div = 0; m_pc = (m_pc == m_psc) ? 0 : m_pc + 1; end
                else m_div++;
            end
            if (rst_t) m_cnt = m_init;
            else if (dec) m_cnt = (m_cnt == 0) ? m_init : m_cnt - 1;
            if (start) m_wait = (wr_data[2:1] == 2);
            else if (!m_run) m_wait = 0;
            else if (fall) m_wait = 0;
            if (eoc) begin m_sq = !m_sq; m_pwq = m_pb; end
            m_irq = eoc;
            m_q3 = m_q2; m_q2 = m_q1; m_q1 = tin;
            if (wr_en) begin
                if (wr_addr == 0) m_init = wr_data;
                else if (wr_addr == 1) m_psc = wr_data[7:0];
                else if (wr_addr == 2) begin
                    m_run = wr_data[0]; m_mode = wr_data[2:1]; m_oe = wr_data[3];
                    m_pm = wr_data[4]; m_pb = wr_data[5];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cyc > 2) begin
            int mt;
            mt = m_oe ? (m_pm ? m_pwq : m_sq) : 1;
            chk(tout == mt, {tag, " tout"}, tout, mt);
            chk(eoc_irq == m_irq, {tag, " irq"}, eoc_irq, m_irq);
        end
    end

    // Watchdog.
    always @(posedge clk) if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(input int max, output bit got, output int at);
        got = 0; at = 0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (eoc_irq) begin got = 1; at = cyc; break; end
        end
    endtask

    task automatic count_irq(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (eoc_irq) c++;
        end
    endtask

    initial begin
        bit got; int t1, t2, c; logic prev;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(tout == 1'b1, "R1 reset tout", tout, 1);
        chk(eoc_irq == 1'b0, "R1 reset irq", eoc_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tout == 1'b1, "R1 after reset tout", tout, 1);

        // R2 / R11 free-running period, square output: init 3, prescaler 1 -> 32
        tag = "R2";
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd1);
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h0009);
        wait_irq(100, got, t1);
        chk(got, "R2 first irq", got, 1);
        wait_irq(100, got, t2);
        chk(t2 - t1 == 32, "R2 period", t2 - t1, 32);
        // R3 pulse width
        @(negedge clk);
        chk(eoc_irq == 1'b0, "R3 irq single cycle", eoc_irq, 0);

        // R9 square wave toggles at end of count
        tag = "R9";
        prev = tout;
        wait_irq(100, got, t1);
        chk(tout == ~prev, "R9 toggle at eoc", tout, ~prev);
        prev = tout;
        repeat (20) @(negedge clk);
        chk(tout == prev, "R9 hold between eoc", tout, prev);

        // R10 PWM latch: bit 0, then bit 1 after an eoc
        tag = "R10";
        wr(2'd2, 16'h0019);
        wait_irq(100, got, t1);
        chk(tout == 1'b0, "R10 pwm low at eoc", tout, 0);
        wr(2'd2, 16'h0039);
        chk(tout == 1'b0, "R10 pwm held before eoc", tout, 0);
        wait_irq(100, got, t1);
        chk(tout == 1'b1, "R10 pwm high at eoc", tout, 1);

        // R8 output disabled
        tag = "R8";
        wr(2'd2, 16'h0001);
        chk(tout == 1'b1, "R8 disabled high", tout, 1);
        wait_irq(100, got, t1);
        chk(tout == 1'b1, "R8 disabled high at eoc", tout, 1);

        // R7 stop
        tag = "R7";
        wr(2'd2, 16'h0000);
        count_irq(200, c);
        chk(c == 0, "R7 no irq after stop", c, 0);

        // R4 gated
        tag = "R4";
        tin = 1'b0;
        wr(2'd2, 16'h0003);
        count_irq(300, c);
        chk(c == 0, "R4 gated low holds", c, 0);
        tin = 1'b1;
        wait_irq(100, got, t1);
        chk(got, "R4 gated high counts", got, 1);
        tin = 1'b0;
        repeat (4) @(negedge clk);
        count_irq(300, c);
        chk(c == 0, "R4 gated low again holds", c, 0);
        wr(2'd2, 16'h0000);

        // R5 triggerable
        tag = "R5";
        tin = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd2, 16'h0005);
        count_irq(300, c);
        chk(c == 0, "R5 armed no count", c, 0);
        tin = 1'b0;
        wait_irq(80, got, t1);
        chk(got, "R5 falling edge starts", got, 1);
        wr(2'd2, 16'h0000);

        // R6 retriggerable: edges every 26 cycles hold off a 44-cycle period
        tag = "R6";
        wr(2'd0, 16'd10);
        wr(2'd1, 16'd0);
        tin = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd2, 16'h0007);
        c = 0;
        for (int k = 0; k < 8; k++) begin
            int cc;
            count_irq(20, cc); c += cc;
            tin = 1'b0;
            count_irq(6, cc); c += cc;
            tin = 1'b1;
        end
        chk(c == 0, "R6 edges reload", c, 0);
        wait_irq(70, got, t1);
        chk(got, "R6 irq after edges stop", got, 1);
        wr(2'd2, 16'h0006);
        c = 0;
        for (int k = 0; k < 4; k++) begin
            int cc;
            count_irq(20, cc); c += cc;
            tin = ~tin;
        end
        chk(c == 0, "R6 edges ignored when stopped", c, 0);

        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule